// File: doc/BRIEF.md
# Maskable interrupt latch and enable unit

This block is the maskable interrupt front end of a small 8-bit controller core. It watches twenty request lines, for sources numbered 2 through 21. The rising edge of a request line sets that source's pending bit. A per-source enable exists for sources 4 through 21; sources 2 and 3 are always enabled. A master enable gates the single request to the core.

The core reaches the pending bits, the enables and the master flag over a byte-wide register bus with combinational reads. A pending bit is cleared by writing 0 to it; writing 1 to it does nothing. The core also has two command strobes that set and clear the master flag. The block presents the number of the lowest-numbered pending, enabled source as a vector index. When the core accepts the request, the block clears the master flag and that source's pending bit in the same clock.

Top module: `irq_latch_unit`

## Requirements
- R1: After reset, every pending bit, every per-source enable and the master flag read 0, `irq_o` is 0 and `irq_vec_o` is 0.
- R2: A pending bit is set on the clock edge that samples a 0-to-1 transition of its request line. A line held high does not set the bit again after software has cleared it.
- R3: Pending bits are cleared by writing 0 and kept by writing 1; a write never sets them. Address 0x3C holds sources 2..7 in bits 2..7. Address 0x3D holds sources 8..15 in bits 0..7. Address 0x3E holds sources 16..21 in bits 0..5. Unimplemented bits read 0.
- R4: A write to 0x3C with 0 in bit 4 and 1s in bits 3:2 clears source 4 and leaves sources 2 and 3 pending. A 0 in bits 3:2 clears them.
- R5: When a rising request edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The master flag is bit 0 of 0x3A, and enables 4..7 are bits 4..7 of 0x3A; bits 3:1 of 0x3A read 0. Enables 8..15 are 0x3B bits 0..7. Enables 16..21 are 0x3F bits 0..5.
- R7: `irq_o` is 1 exactly when the master flag is 1 and some source is both pending and enabled, with sources 2 and 3 always counted as enabled.
- R8: `irq_vec_o` gives the number of the lowest-numbered source that is both pending and enabled, or 0 if there is none, whatever the state of the master flag.
- R9: While `irq_o` is 1, `irq_ack_i` clears the master flag and the winning source's pending bit at the next edge. For the master flag, acceptance has priority over `cmd_di`, which has priority over `cmd_ei`, which has priority over a bus write.
- R10: `cmd_ei` sets the master flag and `cmd_di` clears it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cmd_ei | input | 1 | Set-master-enable command |
| cmd_di | input | 1 | Clear-master-enable command |
| src_req_i | input | 20 | Request lines; bit k is source k+2 |
| irq_ack_i | input | 1 | Core acceptance strobe |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 5 | Number of the winning source |

## Verification
The selection logic is tried with several request patterns:
- A lone source 2 shows that the always-enabled sources need no enable bit.
- A source whose enable is off, and then the same source with its enable on, show that the enable gates the request.
- A pending source with the master flag off shows that `irq_vec_o` still follows the winner while `irq_o` stays low.
- Pairs of sources spread over the low, high and extension bytes show that the lowest number wins across byte boundaries.

Directed tests cover:
- clearing source 4 with bits 3:2 held high, then clearing sources 2 and 3;
- a set and a clear arriving together;
- a request line held high across a clear;
- acceptance colliding with the set-master command;
- a reset applied in the middle of a run.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
package irq_unit_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 8'h3A;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 8'h3B;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 8'h3C;
  localparam logic [ADDR_W-1:0] A_EN_EXT = 8'h3F;

  // Pending bytes are contiguous; byte b covers sources 8*b .. 8*b+7.
  function automatic logic [ADDR_W-1:0] lat_addr(input int b);
    return A_LAT_LO + ADDR_W'(b);
  endfunction

  // Enable bytes are not contiguous.
  function automatic logic [ADDR_W-1:0] en_addr(input int b);
    case (b)
      0:       return A_EN_LO;
      1:       return A_EN_HI;
      default: return A_EN_EXT;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/irq_latch_bank.sv
`timescale 1ns/1ps
module irq_latch_bank
  import irq_unit_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int FIRST_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  output logic [NUM_SRC-1:0] lat_o
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] lat_q, lat_d;
  logic [NUM_SRC-1:0] rise, clr;
  logic               lat_upd;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam int SRC  = k + FIRST_SRC;
    localparam int BYTE = SRC / 8;
    localparam int BITP = SRC % 8;
    assign rise[k] = req_i[k] & ~req_q[k];
    assign clr[k]  = (wr_en && (wr_addr == lat_addr(BYTE)) && !wr_data[BITP])
                     || ack_clr_i[k];
  end

  // A new edge overrides any clear in the same cycle.
  always_comb begin
    lat_d   = rise | (lat_q & ~clr);
    lat_upd = (|rise) | (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      lat_q <= '0;
    end else begin
      req_q <= req_i;
      if (lat_upd) lat_q <= lat_d;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/irq_enable_bank.sv
`timescale 1ns/1ps
module irq_enable_bank
  import irq_unit_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int FIRST_SRC = 2,
  parameter int ALWAYS_ON = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               take_i,
  input  logic               ei_i,
  input  logic               di_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               master_o
);
  logic master_q, master_d;

  // Order of precedence: acceptance, disable, enable, bus write.
  always_comb begin
    master_d = master_q;
    if (take_i)                          master_d = 1'b0;
    else if (di_i)                       master_d = 1'b0;
    else if (ei_i)                       master_d = 1'b1;
    else if (wr_en && wr_addr == A_EN_LO) master_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_q <= 1'b0;
    else        master_q <= master_d;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
    if (k < ALWAYS_ON) begin : g_fixed
      assign en_o[k] = 1'b1;
    end else begin : g_reg
      localparam int SRC  = k + FIRST_SRC;
      localparam int BYTE = SRC / 8;
      localparam int BITP = SRC % 8;
      logic en_q;
      logic en_ld;
      assign en_ld = wr_en && (wr_addr == en_addr(BYTE));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_ld) en_q <= wr_data[BITP];
      end
      assign en_o[k] = en_q;
    end
  end

  assign master_o = master_q;
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int NUM_SRC   = 20,
  parameter int FIRST_SRC = 2,
  parameter int VEC_W     = 5
) (
  input  logic [NUM_SRC-1:0] cand_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] win_o
);
  always_comb begin
    any_o = 1'b0;
    vec_o = '0;
    win_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cand_i[k] && !any_o) begin
        any_o    = 1'b1;
        vec_o    = VEC_W'(k + FIRST_SRC);
        win_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_latch_unit.sv
`timescale 1ns/1ps
module irq_latch_unit
  import irq_unit_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int FIRST_SRC = 2,
  parameter int ALWAYS_ON = 2,
  parameter int VEC_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               cmd_ei,
  input  logic               cmd_di,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               irq_ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  localparam int NUM_BYTES = (FIRST_SRC + NUM_SRC + 7) / 8;
  localparam int VIEW_W    = 8 * NUM_BYTES;

  logic                rst_n_int;
  logic [NUM_SRC-1:0]  lat_q, en_q, cand, win, ack_clr;
  logic                master_q, any_cand, take;
  logic [VIEW_W-1:0]   lat_view, en_view;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  irq_latch_bank #(.NUM_SRC(NUM_SRC), .FIRST_SRC(FIRST_SRC)) u_lat (
    .clk(clk), .rst_n(rst_n_int), .req_i(src_req_i),
    .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .ack_clr_i(ack_clr), .lat_o(lat_q)
  );

  irq_enable_bank #(.NUM_SRC(NUM_SRC), .FIRST_SRC(FIRST_SRC),
                    .ALWAYS_ON(ALWAYS_ON)) u_en (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .take_i(irq_ack_i), .ei_i(cmd_ei), .di_i(cmd_di),
    .en_o(en_q), .master_o(master_q)
  );

  assign cand = lat_q & en_q;

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .FIRST_SRC(FIRST_SRC),
                  .VEC_W(VEC_W)) u_pick (
    .cand_i(cand), .any_o(any_cand), .vec_o(irq_vec_o), .win_o(win)
  );

  assign irq_o   = master_q & any_cand;
  assign take    = irq_ack_i & irq_o;
  assign ack_clr = win & {NUM_SRC{take}};

  // Byte views indexed by source number; the master flag sits at bit 0.
  always_comb begin
    lat_view = '0;
    en_view  = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      lat_view[k + FIRST_SRC] = lat_q[k];
      if (k >= ALWAYS_ON) en_view[k + FIRST_SRC] = en_q[k];
    end
    en_view[0] = master_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (bus_addr == lat_addr(b)) bus_rdata = lat_view[8*b +: 8];
      if (bus_addr == en_addr(b))  bus_rdata = en_view[8*b +: 8];
    end
  end
endmodule

// File: rtl/irq_latch_unit_chk.sv
`timescale 1ns/1ps
module irq_latch_unit_chk #(
  parameter int NUM_SRC   = 20,
  parameter int FIRST_SRC = 2,
  parameter int VEC_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic               irq_ack_i,
  input logic               cmd_di,
  input logic               irq_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [NUM_SRC-1:0] lat_q
);
  localparam int LAST_SRC = FIRST_SRC + NUM_SRC - 1;

  // R9: acceptance leaves no request in the following cycle
  p_ack_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> !irq_o);

  // R10: a disable command masks the request on the next cycle
  p_di_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> !irq_o);

  // R7: a raised request always names a real source
  p_irq_has_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o >= VEC_W'(FIRST_SRC)));

  // R8: the vector is zero or a valid source number
  p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec_o == '0) || ((irq_vec_o >= VEC_W'(FIRST_SRC)) &&
                          (irq_vec_o <= VEC_W'(LAST_SRC))));

  // R3: without a bus write or an acceptance no pending bit is lost
  p_no_silent_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !irq_ack_i) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
endmodule

bind irq_latch_unit irq_latch_unit_chk #(
  .NUM_SRC(NUM_SRC), .FIRST_SRC(FIRST_SRC), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .irq_ack_i(irq_ack_i),
  .cmd_di(cmd_di), .irq_o(irq_o), .irq_vec_o(irq_vec_o), .lat_q(lat_q)
);

// File: tb/irq_latch_unit_tb_top.sv
`timescale 1ns/1ps
module irq_latch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        cmd_ei, cmd_di;
  logic [19:0] src_req_i;
  logic        irq_ack_i;
  logic        irq_o;
  logic [4:0]  irq_vec_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_latch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_ei(cmd_ei),
    .cmd_di(cmd_di), .src_req_i(src_req_i), .irq_ack_i(irq_ack_i),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  // {en 0x3A, en 0x3B, en 0x3F, request pattern, expected irq, expected vec}
  localparam logic [49:0] VTAB [7] = '{
    {8'h01, 8'h00, 8'h00, 20'h00001, 1'b1, 5'd2},
    {8'h01, 8'h00, 8'h00, 20'h00008, 1'b0, 5'd0},
    {8'h21, 8'h00, 8'h00, 20'h00008, 1'b1, 5'd5},
    {8'h00, 8'hFF, 8'h00, 20'h00080, 1'b0, 5'd9},
    {8'h01, 8'h80, 8'h20, 20'h82000, 1'b1, 5'd15},
    {8'h01, 8'h00, 8'h3F, 20'h44000, 1'b1, 5'd16},
    {8'h11, 8'h00, 8'h00, 20'h00006, 1'b1, 5'd3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a,
                        input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [19:0] p);
    src_req_i = p; tick();
    src_req_i = '0; tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic clear_all();
    wr(8'h3C, 8'h00); wr(8'h3D, 8'h00); wr(8'h3E, 8'h00);
    wr(8'h3A, 8'h00); wr(8'h3B, 8'h00); wr(8'h3F, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    cmd_ei = 1'b0; cmd_di = 1'b0; src_req_i = '0; irq_ack_i = 1'b0;
    do_reset();

    // R1: state after reset
    chk("R1 irq", irq_o, 0);
    chk("R1 vec", irq_vec_o, 0);
    rd_chk("R1 3A", 8'h3A, 8'h00); rd_chk("R1 3B", 8'h3B, 8'h00);
    rd_chk("R1 3C", 8'h3C, 8'h00); rd_chk("R1 3D", 8'h3D, 8'h00);
    rd_chk("R1 3E", 8'h3E, 8'h00); rd_chk("R1 3F", 8'h3F, 8'h00);

    // R7 R8: table of selection patterns
    for (int i = 0; i < 7; i++) begin
      clear_all();
      wr(8'h3B, VTAB[i][41:34]);
      wr(8'h3F, VTAB[i][33:26]);
      wr(8'h3A, VTAB[i][49:42]);
      pulse(VTAB[i][25:6]);
      chk($sformatf("R7 irq vec%0d", i), irq_o, VTAB[i][5]);
      chk($sformatf("R8 vec vec%0d", i), irq_vec_o, VTAB[i][4:0]);
    end
    clear_all();

    // R6: enable register map
    wr(8'h3A, 8'hFF); rd_chk("R6 3A", 8'h3A, 8'hF1);
    wr(8'h3B, 8'hA5); rd_chk("R6 3B", 8'h3B, 8'hA5);
    wr(8'h3F, 8'hFF); rd_chk("R6 3F", 8'h3F, 8'h3F);
    clear_all();

    // R3: writing 1s never sets a pending bit
    wr(8'h3E, 8'hFF); rd_chk("R3 3E ones", 8'h3E, 8'h00);
    wr(8'h3D, 8'hFF); rd_chk("R3 3D ones", 8'h3D, 8'h00);
    pulse(20'h80000); rd_chk("R3 3E src21", 8'h3E, 8'h20);
    wr(8'h3E, 8'hDF); rd_chk("R3 3E clr", 8'h3E, 8'h00);

    // R4: clear source 4 with 1s protecting sources 2 and 3
    pulse(20'h00007); rd_chk("R4 set", 8'h3C, 8'h1C);
    wr(8'h3C, 8'hEC); rd_chk("R4 keep 2,3", 8'h3C, 8'h0C);
    wr(8'h3C, 8'hF0); rd_chk("R4 clr 2,3", 8'h3C, 8'h00);

    // R2: held level does not re-set after a clear
    src_req_i = 20'h00040; tick();
    rd_chk("R2 set", 8'h3D, 8'h01);
    wr(8'h3D, 8'h00); tick();
    rd_chk("R2 held", 8'h3D, 8'h00);
    src_req_i = '0; tick();

    // R5: set and clear in the same cycle
    src_req_i = 20'h00040;
    wr(8'h3D, 8'h00);
    rd_chk("R5 set wins", 8'h3D, 8'h01);
    src_req_i = '0; tick();
    wr(8'h3D, 8'h00);

    // R9: acceptance
    wr(8'h3A, 8'h01);
    pulse(20'h00003);
    chk("R9 pre irq", irq_o, 1); chk("R9 pre vec", irq_vec_o, 2);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk("R9 irq", irq_o, 0); chk("R9 vec", irq_vec_o, 3);
    rd_chk("R9 latch", 8'h3C, 8'h08); rd_chk("R9 master", 8'h3A, 8'h00);

    // R10: commands
    cmd_ei = 1'b1; tick(); cmd_ei = 1'b0;
    chk("R10 ei", irq_o, 1);
    cmd_di = 1'b1; tick(); cmd_di = 1'b0;
    chk("R10 di", irq_o, 0);
    cmd_ei = 1'b1; tick();
    irq_ack_i = 1'b1; tick();
    cmd_ei = 1'b0; irq_ack_i = 1'b0;
    rd_chk("R9 ack over ei", 8'h3A, 8'h00);
    rd_chk("R9 winner cleared", 8'h3C, 8'h00);

    // R1: reset in the middle of a run
    wr(8'h3A, 8'hF1); wr(8'h3F, 8'h3F); pulse(20'h00001);
    chk("R1 pre", irq_o, 1);
    do_reset();
    chk("R1 mid irq", irq_o, 0);
    rd_chk("R1 mid 3A", 8'h3A, 8'h00); rd_chk("R1 mid 3F", 8'h3F, 8'h00);
    rd_chk("R1 mid 3C", 8'h3C, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule